// File: doc/BRIEF.md
# Tile Row Pixel Decoder

The decoder turns one row of a 4-bit-per-pixel character pattern into a stream of eight color indices. A start pulse supplies a 16-bit tile attribute word, a line number within the tile, and two mode bits: interlace and transparent. The block then works out the byte address of the 32-bit pattern row and reads that row once through a synchronous memory port with one cycle of latency. It then emits the row's eight pixels, one per accepted beat, on a valid/ready output stream.

Each beat carries a 6-bit color index, which is the palette number times 16 plus the pixel value. It also carries a 3-bit screen column and a write enable. The write enable is low for transparent pixels in transparent mode. Horizontal and vertical flip are applied inside the block, so the consumer only needs the column to place each pixel. In transparent mode a row that is all zero ends the operation at once, with no beats.

Back-pressure: a beat is transferred in a cycle where `pix_valid` and `pix_ready` are both high. While `pix_valid` is high and `pix_ready` is low, the beat's color, column and write enable stay unchanged. The block never withdraws a beat. The start, busy and done pins are plain control signals.

Top module: `tile_row_decoder`

## Requirements
- R1: Attribute fields are: pattern index = attr[10:0], horizontal flip = attr[11], vertical flip = attr[12], palette = attr[14:13]. attr[15] has no effect on the address or on any beat.
- R2: The row used is line, or line XOR 7 when vertical flip is set. In normal mode (interlace=0) the byte address is index*32 + row*4.
- R3: In interlace mode (interlace=1) the byte address is index*64 + row*8.
- R4: Each operation asserts `mem_rd_en` for exactly one cycle with a valid `mem_addr`. `mem_rd_data` is taken in the cycle after that read cycle.
- R5: Without horizontal flip, beats k=0..7 carry `pix_col`=k and the nibble at bit position lsb(k), where lsb(p) = (p/2)*8 + (p odd ? 0 : 4). The resulting order is bits [7:4], [3:0], [15:12], [11:8], [23:20], [19:16], [31:28], [27:24].
- R6: With horizontal flip, beat k carries `pix_col`=k and the nibble at lsb(7-k), which is the unflipped sequence in exact reverse order.
- R7: `pix_color` = palette*16 + nibble. In solid mode (transparent=0) every beat has `pix_wr_en`=1, including beats with nibble 0.
- R8: In transparent mode a beat whose nibble is 0 has `pix_wr_en`=0. The beat is still presented and its column still advances.
- R9: In transparent mode a fetched row equal to 0 produces no beats, and the operation finishes with a done pulse.
- R10: While `pix_valid`=1 and `pix_ready`=0, the beat (color, column, write enable) is held unchanged, and it is still valid in the next cycle.
- R11: `busy` is high from the cycle after an accepted start until the operation ends. `done` is a one-cycle pulse with `busy` low. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| attr | input | 16 | Tile attribute word |
| line | input | 3 | Line within the tile |
| interlace | input | 1 | 1 = double-size pattern addressing |
| transparent | input | 1 | 1 = zero pixels not written, blank rows skipped |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_rd_en | output | 1 | Pattern memory read strobe |
| mem_addr | output | IDX_W+6 | Byte address of the pattern row |
| mem_rd_data | input | 32 | Row word, valid one cycle after the read |
| pix_valid | output | 1 | Beat available |
| pix_ready | input | 1 | Consumer accepts the beat |
| pix_color | output | 6 | Palette*16 + pixel value |
| pix_col | output | 3 | Screen column 0..7 |
| pix_wr_en | output | 1 | Write this pixel |

## Verification
The bench sweeps every combination of mode, flip and line, over pattern indices at both ends of the range and all palettes, while stalling the stream with a pseudo-random ready. The swapped-nibble order inside each byte is a key target: a design that took nibbles low-first would emit pairs swapped, and horizontal flip would expose an off-by-one reversal. Blank rows at low addresses check that transparent mode aborts without beats while solid mode still writes eight zero pixels. A start pulse injected mid-operation with a different attribute would corrupt the address or colors if the design accepted it.

// File: rtl/tile_dec_pkg.sv
package tile_dec_pkg;
  localparam int ROW_W  = 32;
  localparam int NIB_W  = 4;
  localparam int PIX_N  = ROW_W / NIB_W;
  localparam int COL_W  = $clog2(PIX_N);
  localparam int PAL_W  = 2;
  localparam int CLR_W  = PAL_W + NIB_W;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_LATCH, ST_EMIT} dec_state_t;
endpackage

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int IDX_W = 11,
  localparam int ADDR_W = IDX_W + 6
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        line,
  input  logic              vflip,
  input  logic              interlace,
  output logic [ADDR_W-1:0] addr
);
  logic [2:0] row;

  always_comb begin
    row = line ^ {3{vflip}};
    // 64-byte patterns use 8-byte row spacing; 32-byte ones use 4
    if (interlace) addr = {idx, row, 3'b000};
    else           addr = {1'b0, idx, row, 2'b00};
  end
endmodule

// File: rtl/tile_nibble_pick.sv
module tile_nibble_pick
  import tile_dec_pkg::*;
(
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] step,
  input  logic             hflip,
  output logic [NIB_W-1:0] nib
);
  logic [NIB_W-1:0] by_pos [PIX_N];
  logic [COL_W-1:0] pos;

  // screen position p lives in byte p/2, high nibble first
  for (genvar g = 0; g < PIX_N; g++) begin : g_pos
    localparam int LSB = (g / 2) * 8 + ((g % 2) != 0 ? 0 : NIB_W);
    assign by_pos[g] = row[LSB +: NIB_W];
  end

  always_comb begin
    pos = hflip ? ~step : step;
    nib = by_pos[pos];
  end
endmodule

// File: rtl/tile_row_decoder.sv
module tile_row_decoder
  import tile_dec_pkg::*;
#(
  parameter int IDX_W = 11,
  localparam int ADDR_W = IDX_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       attr,
  input  logic [2:0]        line,
  input  logic              interlace,
  input  logic              transparent,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ROW_W-1:0]  mem_rd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [CLR_W-1:0]  pix_color,
  output logic [COL_W-1:0]  pix_col,
  output logic              pix_wr_en
);
  dec_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             hflip_q, vflip_q, ilace_q, trans_q;
  logic [PAL_W-1:0] pal_q;
  logic [2:0]       line_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] step_q;
  logic [NIB_W-1:0] nib;
  logic             last_beat;

  tile_addr_gen #(.IDX_W(IDX_W)) u_addr (
    .idx(idx_q), .line(line_q), .vflip(vflip_q),
    .interlace(ilace_q), .addr(mem_addr)
  );

  tile_nibble_pick u_pick (
    .row(row_q), .step(step_q), .hflip(hflip_q), .nib(nib)
  );

  assign busy      = (state_q != ST_IDLE);
  assign mem_rd_en = (state_q == ST_READ);
  assign pix_valid = (state_q == ST_EMIT);
  assign pix_color = {pal_q, nib};
  assign pix_col   = step_q;
  assign pix_wr_en = pix_valid && (!trans_q || (nib != '0));
  assign last_beat = (step_q == COL_W'(PIX_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      hflip_q <= 1'b0;
      vflip_q <= 1'b0;
      ilace_q <= 1'b0;
      trans_q <= 1'b0;
      pal_q   <= '0;
      line_q  <= '0;
      row_q   <= '0;
      step_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          idx_q   <= attr[IDX_W-1:0];
          hflip_q <= attr[11];
          vflip_q <= attr[12];
          pal_q   <= attr[14:13];
          line_q  <= line;
          ilace_q <= interlace;
          trans_q <= transparent;
          state_q <= ST_READ;
        end
        ST_READ: state_q <= ST_LATCH;
        ST_LATCH: begin
          row_q  <= mem_rd_data;
          step_q <= '0;
          if (trans_q && (mem_rd_data == '0)) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: if (pix_ready) begin
          if (last_beat) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_row_decoder_chk.sv
module tile_row_decoder_chk
  import tile_dec_pkg::*;
#(
  parameter int IDX_W = 11,
  localparam int ADDR_W = IDX_W + 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [CLR_W-1:0]  pix_color,
  input logic [COL_W-1:0]  pix_col,
  input logic              pix_wr_en
);
  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_color)
      && $stable(pix_col) && $stable(pix_wr_en));

  a_r5_col_steps: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && (pix_col != COL_W'(PIX_N - 1))
      |=> pix_valid && (pix_col == $past(pix_col) + 1'b1));

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r4_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r8_wr_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    pix_wr_en |-> pix_valid);

  a_r11_work_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid || mem_rd_en) |-> busy);
endmodule

bind tile_row_decoder tile_row_decoder_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tile_row_decoder_test.sv
`timescale 1ns/1ps
module tile_row_decoder_test;
  localparam int IDX_W  = 11;
  localparam int ADDR_W = IDX_W + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, interlace = 1'b0, transparent = 1'b0, pix_ready = 1'b0;
  logic [15:0] attr = '0;
  logic [2:0]  line = '0;
  logic busy, done, mem_rd_en, pix_valid, pix_wr_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_rd_data = '0;
  logic [5:0]  pix_color;
  logic [2:0]  pix_col;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tile_row_decoder #(.IDX_W(IDX_W)) uut (.*);

  function automatic logic [31:0] row_of(int a);
    logic [31:0] p;
    p = 32'(a) * 32'h9E3779B1;
    return (a < 16) ? 32'h0 : (p & 32'hF0FF0FF0);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= row_of(int'(mem_addr));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [15:0] a, int ln, bit il, bit tr, bit poke);
    int idx, row, ea, beats, reads, pos, lsb, nib, cyc;
    logic [31:0] d;
    bit hf;
    idx = int'(a[10:0]);
    hf  = a[11];
    row = a[12] ? (ln ^ 7) : ln;
    ea  = il ? idx * 64 + row * 8 : idx * 32 + row * 4;
    d   = row_of(ea);
    @(negedge clk);
    attr = a; line = 3'(ln); interlace = il; transparent = tr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    beats = 0; reads = 0; cyc = 0;
    while (1) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready = lfsr[0] | lfsr[1];
      if (poke && cyc == 1) begin
        start = 1'b1; attr = ~a; line = ~line;
      end else start = 1'b0;
      #0.5;
      if (mem_rd_en) begin
        reads++;
        if (il) chk(int'(mem_addr) == ea, "R3 interlace address", int'(mem_addr), ea);
        else    chk(int'(mem_addr) == ea, "R2 normal address", int'(mem_addr), ea);
      end
      if (pix_valid && pix_ready) begin
        pos = hf ? 7 - beats : beats;
        lsb = (pos / 2) * 8 + ((pos % 2) != 0 ? 0 : 4);
        nib = int'((d >> lsb) & 32'hF);
        chk(int'(pix_col) == beats, "R5 column", int'(pix_col), beats);
        if (hf) chk(int'(pix_color) == int'(a[14:13]) * 16 + nib, "R6 flipped color",
                    int'(pix_color), int'(a[14:13]) * 16 + nib);
        else    chk(int'(pix_color) == int'(a[14:13]) * 16 + nib, "R5 R1 color",
                    int'(pix_color), int'(a[14:13]) * 16 + nib);
        if (tr) chk(pix_wr_en == (nib != 0), "R8 transparent write", pix_wr_en, nib != 0);
        else    chk(pix_wr_en == 1'b1, "R7 solid write", pix_wr_en, 1);
        beats++;
      end
      if (done) break;
      cyc++;
      if (cyc > 100) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R11 done pulse idle", {done, busy}, 2);
    chk(reads == 1, "R4 single read", reads, 1);
    if (tr && d == 0) chk(beats == 0, "R9 blank row skipped", beats, 0);
    else              chk(beats == 8, "R10 eight beats", beats, 8);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idxs [4] = '{0, 1, 2047, 682};
    repeat (3) @(negedge clk);
    chk({busy, done, pix_valid, mem_rd_en} == 4'b0, "R11 reset state",
        {busy, done, pix_valid, mem_rd_en}, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int hv = 0; hv < 4; hv++)
        for (int ln = 0; ln < 8; ln++)
          for (int ii = 0; ii < 4; ii++) begin
            logic [15:0] a;
            a = {1'(ln), 2'((ln + ii) % 4), 1'(hv >> 1), 1'(hv), 11'(idxs[ii])};
            run_op(a, ln, m[0], m[1], ln == 5);
          end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule